// File: doc/BRIEF.md
# One-Shot Test Pattern Injector

This block sits on the data path of a group of input links. For each link it holds a pattern memory that the host loads. Under host control it can put the contents of those memories on the outputs in place of the live link data, for a single pass. Injection is guarded by two separate conditions. The host must first raise a level-sensitive arm input. Then a single-cycle test-enable strobe must arrive from the timing system. When both are true, every link plays its stored words once, starting at address 0, one word per crossing clock. The outputs then return to live data. The stored words are not erased, so the same pattern can be fired again later.

Every test-enable strobe stores the current crossing counter value in a timestamp register. This happens whether or not the strobe starts a playback, so the host can tell when the last strobe arrived. A busy output is high while a playback is in progress. Decoding of the host bus and of the timing commands is done elsewhere. This block receives a write port, a decoded strobe and a crossing counter.

Top module: `tpi_injector`

## Requirements
- R1: After reset, `busy` is 0 and `trig_bx` is 0.
- R2: A host write with `wr_en`=1 stores `wr_data` at `wr_addr` only in the memory of link `wr_link`. Every link therefore plays its own data.
- R3: When `arm`=1 and no `test_en` arrives, nothing is injected. Each link output equals that link's live input from one clock earlier, and `busy` stays 0.
- R4: A `test_en` strobe while `arm`=0 starts no playback. The outputs stay on live data and `busy` stays 0.
- R5: A `test_en` strobe at clock edge E0, with `arm`=1 and `busy`=0, sets `busy` from E0. After edge E0+k, for k = 1 to DEPTH, link i outputs the word stored at address k-1 of its memory.
- R6: `busy` stays high for exactly DEPTH clock cycles per playback. It falls at edge E0+DEPTH.
- R7: From edge E0+DEPTH+1 onward, the outputs carry live data again, with the same one-clock latency as in R3.
- R8: Playback leaves the memories unchanged. A second trigger replays the same words.
- R9: During a playback, further `test_en` strobes are ignored and do not restart or extend it. Clearing `arm` does not cut it short. A strobe on the cycle in which `busy` falls is also ignored.
- R10: Every `test_en` strobe loads `bx_cnt` into `trig_bx` on the same edge. This applies with or without `arm` and during a playback.
- R11: A host write to the memory between playbacks changes the word that the next playback outputs at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Host arm level; first protection stage |
| test_en | input | 1 | Decoded test-enable strobe, one cycle wide |
| bx_cnt | input | BX_W | Current crossing number |
| wr_en | input | 1 | Host memory write strobe |
| wr_link | input | LINK_W | Link whose memory is written |
| wr_addr | input | ADDR_W | Word address of the host write |
| wr_data | input | DATA_W | Word written by the host |
| live_data | input | NUM_LINKS*DATA_W | Live link words, link i at bits [i*DATA_W +: DATA_W] |
| out_data | output | NUM_LINKS*DATA_W | Injected or live words, same packing as the input |
| busy | output | 1 | High while a playback runs |
| trig_bx | output | BX_W | Crossing number of the last test-enable strobe |

## Verification
The bench builds the block with three links, 10-bit words and a memory depth of 16. The short depth lets full playbacks be checked word by word, several times per run. It also brings both corners of a playback within reach: the first output word, and the last cycle on which a late strobe has to be rejected. Three links make a mix-up in the write-select decoding or in the packing of the output visible. Timestamps are compared against a free-running 12-bit crossing counter that the bench drives.

// File: rtl/tpi_pkg.sv
// Shared types for the test pattern injector.
// Assumes: nothing beyond IEEE 1800-2017.
package tpi_pkg;

    // Playback controller states.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PLAY = 1'b1
    } play_state_e;

endpackage

// File: rtl/tpi_pattern_ram.sv
// Pattern memory for one link. It has a single write port from the host
// and a registered read port for playback.
// Assumes: DEPTH is a power of two. The contents are never cleared by reset.
module tpi_pattern_ram #(
    parameter int DATA_W = 10,
    parameter int DEPTH  = 128,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Host write into the storage array.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Registered read for the playback path.
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/tpi_play_ctrl.sv
// One-shot playback sequencer. An armed test-enable starts one pass over
// addresses 0..DEPTH-1. Strobes that arrive while a pass runs are ignored.
// sel_pat is busy delayed by one clock, so it lines up with the registered
// memory read.
// Assumes: test_en is a single-cycle strobe and arm is a level.
module tpi_play_ctrl
    import tpi_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              test_en,
    output logic              busy,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              sel_pat
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    play_state_e       state;
    logic [ADDR_W-1:0] addr;
    logic              start;

    // A pass may only begin from idle with both protection stages met.
    always_comb begin
        start = (state == ST_IDLE) && arm && test_en;
    end

    // State and address sequencing for a single pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            addr  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_PLAY;
                        addr  <= '0;
                    end
                end
                ST_PLAY: begin
                    if (addr == LAST_ADDR) begin
                        state <= ST_IDLE;
                        addr  <= '0;
                    end else begin
                        addr <= addr + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output select, aligned with the one-cycle memory read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_pat <= 1'b0;
        end else begin
            sel_pat <= (state == ST_PLAY);
        end
    end

    assign busy    = (state == ST_PLAY);
    assign rd_addr = addr;

endmodule

// File: rtl/tpi_stamp.sv
// Timestamp register. It stores the crossing number on every test-enable
// strobe, whether or not that strobe starts a playback.
// Assumes: bx_cnt is synchronous to clk.
module tpi_stamp #(
    parameter int BX_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            test_en,
    input  logic [BX_W-1:0] bx_cnt,
    output logic [BX_W-1:0] trig_bx
);

    // Capture the crossing number of the latest strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_bx <= '0;
        end else if (test_en) begin
            trig_bx <= bx_cnt;
        end
    end

endmodule

// File: rtl/tpi_injector.sv
// Top of the one-shot test pattern injector. It holds one pattern memory per
// link and one shared sequencer. Each link output is either its registered
// live word or its memory word, so both paths have one clock of latency.
// Assumes: host writes and the strobe are already decoded into this clock domain.
module tpi_injector #(
    parameter int NUM_LINKS = 4,
    parameter int DATA_W    = 10,
    parameter int DEPTH     = 128,
    parameter int BX_W      = 12,
    localparam int ADDR_W   = $clog2(DEPTH),
    localparam int LINK_W   = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1,
    localparam int BUS_W    = NUM_LINKS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              test_en,
    input  logic [BX_W-1:0]   bx_cnt,
    input  logic              wr_en,
    input  logic [LINK_W-1:0] wr_link,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BUS_W-1:0]  live_data,
    output logic [BUS_W-1:0]  out_data,
    output logic              busy,
    output logic [BX_W-1:0]   trig_bx
);

    logic [ADDR_W-1:0] rd_addr;
    logic              sel_pat;

    // Shared sequencer for all links.
    tpi_play_ctrl #(
        .DEPTH (DEPTH)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .test_en (test_en),
        .busy    (busy),
        .rd_addr (rd_addr),
        .sel_pat (sel_pat)
    );

    // Crossing timestamp of the last strobe.
    tpi_stamp #(
        .BX_W (BX_W)
    ) u_stamp (
        .clk     (clk),
        .rst_n   (rst_n),
        .test_en (test_en),
        .bx_cnt  (bx_cnt),
        .trig_bx (trig_bx)
    );

    // One memory, one live register and one output mux per link.
    for (genvar li = 0; li < NUM_LINKS; li++) begin : g_link
        logic              we_link;
        logic [DATA_W-1:0] pat_word;
        logic [DATA_W-1:0] live_q;

        assign we_link = wr_en && (wr_link == LINK_W'(li));

        tpi_pattern_ram #(
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH)
        ) u_ram (
            .clk   (clk),
            .we    (we_link),
            .waddr (wr_addr),
            .wdata (wr_data),
            .raddr (rd_addr),
            .rdata (pat_word)
        );

        // Register the live word so both output sources have equal latency.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live_q <= '0;
            end else begin
                live_q <= live_data[li*DATA_W +: DATA_W];
            end
        end

        // Choose the pattern word during a pass and the live word otherwise.
        always_comb begin
            out_data[li*DATA_W +: DATA_W] = sel_pat ? pat_word : live_q;
        end
    end

endmodule

// File: rtl/tpi_injector_chk.sv
// Assertion checker for tpi_injector, attached with bind.
// Assumes: it is bound with the same parameter values as the top module.
module tpi_injector_chk #(
    parameter int NUM_LINKS = 4,
    parameter int DATA_W    = 10,
    parameter int DEPTH     = 128,
    parameter int BX_W      = 12,
    localparam int BUS_W    = NUM_LINKS * DATA_W,
    localparam int CNT_W    = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm,
    input logic             test_en,
    input logic [BX_W-1:0]  bx_cnt,
    input logic [BUS_W-1:0] live_data,
    input logic [BUS_W-1:0] out_data,
    input logic             busy,
    input logic [BX_W-1:0]  trig_bx
);

    logic             seen;
    logic [CNT_W-1:0] run_cnt;

    // Marks that at least one clock edge has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    // Counts the cycles of the current pass.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_cnt <= '0;
        else if (busy) run_cnt <= run_cnt + 1'b1;
        else           run_cnt <= '0;
    end

    // R1: busy is low in the first cycle after reset.
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen |-> !busy);

    // R3/R4/R7: when the previous cycle was not busy, the outputs carry live data.
    p_live_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !$past(busy)) |-> (out_data == $past(live_data)));

    // R4: no pass starts without both arm and a strobe.
    p_no_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(arm && test_en)) |=> !busy);

    // R5: an armed strobe from idle starts a pass.
    p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && arm && test_en) |=> busy);

    // R6/R9: busy holds until DEPTH cycles have passed, whatever arm and test_en do.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (run_cnt < CNT_W'(DEPTH - 1))) |=> busy);

    // R6: busy drops after exactly DEPTH cycles.
    p_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (run_cnt == CNT_W'(DEPTH - 1))) |=> !busy);

    // R10: every strobe updates the timestamp.
    p_stamp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        test_en |=> (trig_bx == $past(bx_cnt)));

    // R10: without a strobe the timestamp holds.
    p_stamp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !test_en) |=> $stable(trig_bx));

endmodule

bind tpi_injector tpi_injector_chk #(
    .NUM_LINKS (NUM_LINKS),
    .DATA_W    (DATA_W),
    .DEPTH     (DEPTH),
    .BX_W      (BX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .test_en   (test_en),
    .bx_cnt    (bx_cnt),
    .live_data (live_data),
    .out_data  (out_data),
    .busy      (busy),
    .trig_bx   (trig_bx)
);

// File: tb/tpi_injector_tb.sv
// Directed bench for tpi_injector. Each scenario is one task that checks its own results.
module tpi_injector_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NL     = 3;
    localparam int DW     = 10;
    localparam int DEPTH  = 16;
    localparam int BXW    = 12;
    localparam int AW     = $clog2(DEPTH);
    localparam int LW     = $clog2(NL);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              arm = 1'b0;
    logic              test_en = 1'b0;
    logic [BXW-1:0]    bx_cnt = '0;
    logic              wr_en = 1'b0;
    logic [LW-1:0]     wr_link = '0;
    logic [AW-1:0]     wr_addr = '0;
    logic [DW-1:0]     wr_data = '0;
    logic [NL*DW-1:0]  live_data;
    logic [NL*DW-1:0]  out_data;
    logic              busy;
    logic [BXW-1:0]    trig_bx;

    logic [DW-1:0] exp_mem [NL][DEPTH];
    int n_tests = 0;
    int n_fail  = 0;

    tpi_injector #(
        .NUM_LINKS (NL),
        .DATA_W    (DW),
        .DEPTH     (DEPTH),
        .BX_W      (BXW)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .test_en   (test_en),
        .bx_cnt    (bx_cnt),
        .wr_en     (wr_en),
        .wr_link   (wr_link),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .live_data (live_data),
        .out_data  (out_data),
        .busy      (busy),
        .trig_bx   (trig_bx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Free-running crossing counter, changed away from the active edge.
    always @(negedge clk) bx_cnt <= bx_cnt + 1'b1;

    // Live words derived from the crossing counter, distinct per link.
    always_comb begin
        for (int i = 0; i < NL; i++) begin
            live_data[i*DW +: DW] = DW'(bx_cnt * 3 + i * 5 + 1);
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_live(input string req);
        for (int i = 0; i < NL; i++) begin
            chk(req, 32'(out_data[i*DW +: DW]), 32'(live_data[i*DW +: DW]));
        end
    endtask

    task automatic host_write(input int link, input int addr, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_link = LW'(link); wr_addr = AW'(addr); wr_data = d;
        exp_mem[link][addr] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 busy", 32'(busy), 0);
        chk("R1 trig_bx", 32'(trig_bx), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 busy after release", 32'(busy), 0);
    endtask

    // R2: every link gets its own contents.
    task automatic t_load;
        for (int i = 0; i < NL; i++) begin
            for (int a = 0; a < DEPTH; a++) begin
                host_write(i, a, DW'(i * 97 + a * 13 + 7));
            end
        end
    endtask

    task automatic t_arm_only;
        @(negedge clk);
        arm = 1'b1; test_en = 1'b0;
        for (int k = 0; k < 10; k++) begin
            @(posedge clk); #1;
            chk_live("R3 arm alone keeps live");
            chk("R3 busy", 32'(busy), 0);
        end
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic t_strobe_unarmed;
        logic [BXW-1:0] bx_at;
        @(negedge clk);
        arm = 1'b0; test_en = 1'b1;
        @(posedge clk); #1;
        bx_at = bx_cnt;
        chk("R10 stamp unarmed", 32'(trig_bx), 32'(bx_at));
        @(negedge clk);
        test_en = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #1;
            chk_live("R4 unarmed strobe keeps live");
            chk("R4 busy", 32'(busy), 0);
        end
    endtask

    // One full pass. extra_at: pass cycle of a second strobe (-1 for none).
    // drop_at: pass cycle on which arm is cleared (-1 for never).
    task automatic run_play(input int extra_at, input int drop_at, input string req);
        for (int k = 0; k <= DEPTH; k++) begin
            @(negedge clk);
            test_en = (k == 0) || (k == extra_at);
            if (k == 0) arm = 1'b1;
            if (k == drop_at) arm = 1'b0;
            @(posedge clk); #1;
            if (test_en) chk("R10 stamp", 32'(trig_bx), 32'(bx_cnt));
            if (k == 0) begin
                chk("R5 busy rises", 32'(busy), 1);
                chk_live("R5 first cycle still live");
            end else begin
                for (int i = 0; i < NL; i++) begin
                    chk(req, 32'(out_data[i*DW +: DW]), 32'(exp_mem[i][k-1]));
                end
                chk("R6 busy length", 32'(busy), (k < DEPTH) ? 1 : 0);
            end
        end
        @(negedge clk);
        test_en = 1'b0; arm = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1;
            chk("R7 idle after pass", 32'(busy), 0);
            chk_live("R7 live resumes");
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 20000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_load();
        t_arm_only();
        t_strobe_unarmed();
        run_play(-1, -1, "R5 R2 pattern word");
        run_play(-1, -1, "R8 replay retained");
        run_play(5, -1, "R9 strobe during pass ignored");
        run_play(DEPTH, 3, "R9 late strobe and arm drop");
        host_write(1, 3, 10'h2AA);
        host_write(2, DEPTH - 1, 10'h155);
        run_play(-1, -1, "R11 rewritten word");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule